// File: doc/BRIEF.md
# Valid-Bit Occupancy Status Detector

This block watches a small buffer in which every entry has its own valid bit. It reports whether the buffer is full, empty or almost full from the valid-bit vector alone, with no read or write pointers. The buffer holds 32 entries of 8-bit words, and its data path lies outside this block.

Almost full means that exactly one entry is free. A pipelined halving search detects this case. Each stage splits the remaining window in two and keeps the half that holds the only zero. A stage abandons the search as soon as it finds a zero in both halves. When exactly one zero exists, the block also reports the position of that zero.

A new vector is sampled on every clock, and the results appear a fixed number of cycles later. The block raises a ready strobe once the pipeline holds results that were sampled after reset.

Top module: `occ_status_detector`

## Requirements
- R1: A synchronous active-high reset drives every status output, the zero index and the ready strobe to 0. After reset is released, the ready strobe rises following the fifth rising edge and stays high until the next reset. While it is low, all status outputs are 0.
- R2: Results for a vector sampled at rising edge e are visible after rising edge e+4. One vector is accepted per clock, and no result is affected by its neighbours.
- R3: The full output is 1 exactly when all 32 valid bits are 1.
- R4: The empty output is 1 exactly when all 32 valid bits are 0.
- R5: The almost-full output is 1 exactly when one valid bit is 0 and the other 31 are 1. Almost-full and full are never 1 together.
- R6: While almost-full is 1, the 5-bit zero index equals the bit position of the single 0 in the vector, where bit i is entry i. The upper 16-bit half of the vector sets index bit 4. At all other times the index is 0.
- R7: The abort output is 1 exactly when the vector holds two or more zeros. This includes the all-zero vector. Abort and almost-full are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| validVec | input | 32 | Valid bit of each buffer entry |
| isFull | output | 1 | All entries valid |
| isEmpty | output | 1 | No entry valid |
| isAlmostFull | output | 1 | Exactly one entry free |
| searchAbort | output | 1 | Halving search stopped, because two or more entries are free |
| zeroIndex | output | 5 | Position of the only free entry, or 0 |
| statusValid | output | 1 | Pipeline holds results sampled after reset |

## Verification
Empty and abort rise together for the all-zero vector, because every empty buffer also has at least two free entries. The bench judges both flags from the same zero count, so the agreement between them is checked on the same cycle. Results also leave the pipeline on the same cycle that a new vector enters it. The bench therefore streams vectors back to back, including every single-zero and every two-zero pattern and vectors with only one bit set. It checks the outputs five edges after each vector is sampled, so a change that stalls or mixes stages shows up against the neighbouring vectors.

// File: rtl/occ_pkg.sv
package occ_pkg;

  // Outcome carried down the halving pipeline next to the window.
  typedef struct packed {
    logic gaveUp;   // both halves held a zero at some level
    logic noZero;   // neither half held a zero: every bit set
    logic full;     // carried from the entry stage
    logic empty;    // carried from the entry stage
  } stageFlags_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic clear;    // wipe every pipeline register
    logic ready;    // last stage holds a post-reset result
  } occCtrl_t;

endpackage

// File: rtl/occ_halve_level.sv
module occ_halve_level
  import occ_pkg::*;
#(
  parameter int IN_W  = 32,
  parameter int IDX_W = 5,
  parameter int LEVEL = 0
) (
  input  logic              clk,
  input  logic              clear,
  input  logic [IN_W-1:0]   winIn,
  input  logic [IDX_W-1:0]  idxIn,
  input  stageFlags_t       flagsIn,
  output logic [IN_W/2-1:0] winOut,
  output logic [IDX_W-1:0]  idxOut,
  output stageFlags_t       flagsOut
);
  localparam int HALF_W  = IN_W / 2;
  localparam int IDX_BIT = IDX_W - 1 - LEVEL;

  logic [HALF_W-1:0] lowHalf;
  logic [HALF_W-1:0] highHalf;
  logic              zeroLow;
  logic              zeroHigh;
  logic              settled;
  logic              pickHigh;
  logic [HALF_W-1:0] winNext;
  logic [IDX_W-1:0]  idxNext;
  stageFlags_t       flagsNext;

  assign lowHalf  = winIn[HALF_W-1:0];
  assign highHalf = winIn[IN_W-1:HALF_W];
  assign zeroLow  = ~&lowHalf;
  assign zeroHigh = ~&highHalf;
  assign settled  = flagsIn.gaveUp | flagsIn.noZero;

  always_comb begin
    flagsNext = flagsIn;
    winNext   = lowHalf;
    pickHigh  = 1'b0;
    if (!settled) begin
      if (zeroLow && zeroHigh) begin
        flagsNext.gaveUp = 1'b1;
      end else if (!zeroLow && !zeroHigh) begin
        flagsNext.noZero = 1'b1;
      end else begin
        pickHigh = zeroHigh;
        winNext  = zeroHigh ? highHalf : lowHalf;
      end
    end
  end

  always_comb begin
    idxNext          = idxIn;
    idxNext[IDX_BIT] = pickHigh;
  end

  always_ff @(posedge clk) begin
    if (clear) begin
      winOut   <= '0;
      idxOut   <= '0;
      flagsOut <= '0;
    end else begin
      winOut   <= winNext;
      idxOut   <= idxNext;
      flagsOut <= flagsNext;
    end
  end

endmodule

// File: rtl/occ_control.sv
module occ_control
  import occ_pkg::*;
#(
  parameter int LEVELS = 5   // at least 2
) (
  input  logic     clk,
  input  logic     rst,
  output occCtrl_t ctrl
);
  logic [LEVELS-1:0] liveQ;

  always_ff @(posedge clk) begin
    if (rst) liveQ <= '0;
    else     liveQ <= {liveQ[LEVELS-2:0], 1'b1};
  end

  assign ctrl.clear = rst;
  assign ctrl.ready = liveQ[LEVELS-1];

endmodule

// File: rtl/occ_datapath.sv
module occ_datapath
  import occ_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int LEVELS      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  occCtrl_t          ctrl,
  input  logic [NUM_ENTRIES-1:0] validVec,
  output logic              isFull,
  output logic              isEmpty,
  output logic              isAlmostFull,
  output logic              searchAbort,
  output logic [LEVELS-1:0] zeroIndex
);
  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    localparam int IN_W = NUM_ENTRIES >> k;
    logic [IN_W-1:0]   winIn;
    logic [IN_W/2-1:0] winOut;
    logic [LEVELS-1:0] idxIn;
    logic [LEVELS-1:0] idxOut;
    stageFlags_t       flagsIn;
    stageFlags_t       flagsOut;

    if (k == 0) begin : g_head
      assign winIn         = validVec;
      assign idxIn         = '0;
      assign flagsIn.gaveUp = 1'b0;
      assign flagsIn.noZero = 1'b0;
      assign flagsIn.full   = &validVec;
      assign flagsIn.empty  = ~|validVec;
    end else begin : g_body
      assign winIn   = g_lvl[k-1].winOut;
      assign idxIn   = g_lvl[k-1].idxOut;
      assign flagsIn = g_lvl[k-1].flagsOut;
    end

    occ_halve_level #(
      .IN_W (IN_W),
      .IDX_W(LEVELS),
      .LEVEL(k)
    ) u_level (
      .clk     (clk),
      .clear   (ctrl.clear),
      .winIn   (winIn),
      .idxIn   (idxIn),
      .flagsIn (flagsIn),
      .winOut  (winOut),
      .idxOut  (idxOut),
      .flagsOut(flagsOut)
    );
  end

  stageFlags_t       lastFlags;
  logic [LEVELS-1:0] lastIdx;
  logic              lastBit;
  logic              oneZero;

  assign lastFlags = g_lvl[LEVELS-1].flagsOut;
  assign lastIdx   = g_lvl[LEVELS-1].idxOut;
  assign lastBit   = g_lvl[LEVELS-1].winOut[0];

  // The surviving single bit must be the zero that was tracked.
  assign oneZero = ~lastFlags.gaveUp & ~lastFlags.noZero & ~lastBit;

  assign isFull       = ctrl.ready & lastFlags.full;
  assign isEmpty      = ctrl.ready & lastFlags.empty;
  assign isAlmostFull = ctrl.ready & oneZero;
  assign searchAbort  = ctrl.ready & lastFlags.gaveUp;
  assign zeroIndex    = (ctrl.ready & oneZero) ? lastIdx : '0;

endmodule

// File: rtl/occ_status_detector.sv
module occ_status_detector
  import occ_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_ENTRIES-1:0] validVec,
  output logic                   isFull,
  output logic                   isEmpty,
  output logic                   isAlmostFull,
  output logic                   searchAbort,
  output logic [IDX_W-1:0]       zeroIndex,
  output logic                   statusValid
);
  occCtrl_t ctrl;

  occ_control #(.LEVELS(IDX_W)) u_control (
    .clk (clk),
    .rst (rst),
    .ctrl(ctrl)
  );

  occ_datapath #(.NUM_ENTRIES(NUM_ENTRIES), .LEVELS(IDX_W)) u_datapath (
    .clk         (clk),
    .ctrl        (ctrl),
    .validVec    (validVec),
    .isFull      (isFull),
    .isEmpty     (isEmpty),
    .isAlmostFull(isAlmostFull),
    .searchAbort (searchAbort),
    .zeroIndex   (zeroIndex)
  );

  assign statusValid = ctrl.ready;

endmodule

// File: rtl/occ_status_checker.sv
module occ_status_checker #(
  parameter int NUM_ENTRIES = 32,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int CNT_W      = $clog2(IDX_W + 1) + 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_ENTRIES-1:0] validVec,
  input logic                   isFull,
  input logic                   isEmpty,
  input logic                   isAlmostFull,
  input logic                   searchAbort,
  input logic [IDX_W-1:0]       zeroIndex,
  input logic                   statusValid
);
  // Counts how many consecutive edges have sampled the same vector.
  logic [NUM_ENTRIES-1:0] prevVec;
  logic [CNT_W-1:0]       heldFor;
  logic                   settledIn;

  always_ff @(posedge clk) begin
    prevVec <= validVec;
    if (rst) heldFor <= '0;
    else if (heldFor != 0 && validVec == prevVec) begin
      if (heldFor < CNT_W'(IDX_W)) heldFor <= heldFor + 1'b1;
    end else heldFor <= CNT_W'(1);
  end

  assign settledIn = statusValid && (heldFor >= CNT_W'(IDX_W));

  AST_QUIET_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
    !statusValid |-> !(isFull || isEmpty || isAlmostFull || searchAbort) && zeroIndex == 0); // R1
  AST_READY_STAYS: assert property (@(posedge clk) disable iff (rst)
    statusValid |=> statusValid); // R1
  AST_FULL_TRACKS: assert property (@(posedge clk) disable iff (rst)
    settledIn |-> isFull == (&prevVec)); // R3
  AST_EMPTY_TRACKS: assert property (@(posedge clk) disable iff (rst)
    settledIn |-> isEmpty == (~|prevVec)); // R4
  AST_ALMOST_TRACKS: assert property (@(posedge clk) disable iff (rst)
    settledIn |-> isAlmostFull == ($countones(~prevVec) == 1)); // R5
  AST_FULL_NOT_ALMOST: assert property (@(posedge clk) disable iff (rst)
    !(isFull && isAlmostFull)); // R5
  AST_IDLE_INDEX_ZERO: assert property (@(posedge clk) disable iff (rst)
    !isAlmostFull |-> zeroIndex == 0); // R6
  AST_INDEX_HITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (settledIn && isAlmostFull) |-> !prevVec[zeroIndex]); // R6
  AST_ABORT_TRACKS: assert property (@(posedge clk) disable iff (rst)
    settledIn |-> searchAbort == ($countones(~prevVec) >= 2)); // R7
  AST_ABORT_NOT_ALMOST: assert property (@(posedge clk) disable iff (rst)
    !(searchAbort && isAlmostFull)); // R7

endmodule

bind occ_status_detector occ_status_checker #(.NUM_ENTRIES(NUM_ENTRIES)) u_checker (
  .clk         (clk),
  .rst         (rst),
  .validVec    (validVec),
  .isFull      (isFull),
  .isEmpty     (isEmpty),
  .isAlmostFull(isAlmostFull),
  .searchAbort (searchAbort),
  .zeroIndex   (zeroIndex),
  .statusValid (statusValid)
);

// File: tb/test_occ_status_detector.sv
`timescale 1ns/1ps
module test_occ_status_detector;
  localparam int N     = 32;
  localparam int IDX_W = 5;
  localparam int LAT   = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [N-1:0]     validVec = '1;
  logic             isFull, isEmpty, isAlmostFull, searchAbort, statusValid;
  logic [IDX_W-1:0] zeroIndex;

  occ_status_detector #(.NUM_ENTRIES(N)) i_occ_status_detector (
    .clk(clk), .rst(rst), .validVec(validVec),
    .isFull(isFull), .isEmpty(isEmpty), .isAlmostFull(isAlmostFull),
    .searchAbort(searchAbort), .zeroIndex(zeroIndex), .statusValid(statusValid)
  );

  always #10 clk = ~clk;

  int           compared = 0;
  int           mismatched = 0;
  int           count = 0;
  bit           finished = 0;
  bit           releasePending = 0;
  logic [N-1:0] hist [0:7];
  logic [31:0]  lfsr = 32'h1D0C_5A37;

  task automatic check1(string req, string what, int actual, int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic checkResult(input logic [N-1:0] v);
    int zeros = 0;
    int pos = 0;
    for (int i = 0; i < N; i++) if (!v[i]) begin zeros++; pos = i; end
    check1("R2", "statusValid at latency", statusValid, 1);
    check1("R3", "isFull", isFull, zeros == 0);
    check1("R4", "isEmpty", isEmpty, zeros == N);
    check1("R5", "isAlmostFull", isAlmostFull, zeros == 1);
    check1("R6", "zeroIndex", zeroIndex, (zeros == 1) ? pos : 0);
    check1("R7", "searchAbort", searchAbort, zeros >= 2);
  endtask

  task automatic applyVec(input logic [N-1:0] v);
    @(negedge clk);
    if (releasePending) begin rst = 1'b0; releasePending = 0; end
    if (count >= LAT) checkResult(hist[(count - LAT) % 8]);
    else check1("R1", "statusValid before fill", statusValid, 0);
    hist[count % 8] = v;
    validVec = v;
    count++;
  endtask

  task automatic doReset(input logic [N-1:0] junk);
    @(negedge clk);
    rst = 1'b1;
    validVec = junk;
    @(negedge clk);
    check1("R1", "reset isFull", isFull, 0);
    check1("R1", "reset isEmpty", isEmpty, 0);
    check1("R1", "reset isAlmostFull", isAlmostFull, 0);
    check1("R1", "reset searchAbort", searchAbort, 0);
    check1("R1", "reset zeroIndex", zeroIndex, 0);
    check1("R1", "reset statusValid", statusValid, 0);
    count = 0;
    releasePending = 1;
  endtask

  task automatic nextRand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  initial begin
    doReset('1);
    applyVec('1);
    applyVec('0);
    applyVec('1);
    for (int i = 0; i < N; i++) applyVec(~(32'd1 << i));        // single free entry
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        applyVec(~((32'd1 << i) | (32'd1 << j)));               // two free entries
    for (int i = 0; i < N; i++) applyVec(32'd1 << i);           // one valid entry
    applyVec('0);
    applyVec(~32'd1);
    for (int k = 0; k < LAT; k++) applyVec('1);
    doReset(32'hFFFF_FFFE);                                     // mid-run reset
    applyVec(~(32'd1 << 31));
    applyVec('0);
    for (int k = 0; k < 1200; k++) begin
      logic [N-1:0] a;
      nextRand(); a = lfsr;
      nextRand();
      case (k % 4)
        0: applyVec(a);
        1: applyVec(a | lfsr);
        2: applyVec(~(32'd1 << lfsr[4:0]));
        default: applyVec(~((32'd1 << lfsr[4:0]) | (32'd1 << a[4:0])));
      endcase
    end
    for (int k = 0; k < LAT; k++) applyVec('1);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule